// File: doc/BRIEF.md
# Micro-Packet Transport Stream Reassembler

The reassembler accepts 32-bit micro-packet words on a valid/ready input and rebuilds 188-byte transport stream packets for four independent streams. Each word names its stream in a 3-bit tag, carries a start-of-packet flag, an upstream-overflow flag, a 3-bit sequence counter and a 24-bit payload slice. A packet is made of 63 slices: the first 62 give three bytes each, the last gives two. Packet alignment comes only from the start flag in the word. The block does not search for a sync byte.

Bytes leave on a single byte-wide output tagged with the stream index, with start-of-packet and end-of-packet markers. Each stream also has two one-cycle event pulses: one for a sequence gap and one for an upstream overflow. Output backpressure holds the input off, so no byte is ever dropped. Each stream keeps its own slice position, last sequence value and first-word state. Bytes come out in the order their words were accepted.

Top module: `mpr_ts_reassembler`

## Requirements
- R1: The tag in word bits 31:29 selects stream tag-1 for tag values 1 to 4. A word with tag 0, 5, 6 or 7 produces no output byte and no event, and changes no stream state.
- R2: A tagged word with bit 25 set starts a new packet on its stream, even part-way through a packet. Its first byte is output with out_sop high.
- R3: A tagged word with bit 25 clear is discarded when its stream is at slice position zero. It produces no output bytes.
- R4: A tagged word with bit 24 set pulses ovf_evt for its stream for one cycle, in the cycle after the word is accepted. This holds for a discarded word too.
- R5: Bits 28:26 form a sequence value. When a tagged word's value differs from that stream's previous value plus one (mod 8), loss_evt for that stream pulses in the cycle after acceptance. The first tagged word after reset is not checked. Every tagged word records its value, including a discarded one.
- R6: A kept slice outputs its payload bytes in the order bits 23:16, 15:8, 7:0.
- R7: The 63rd slice of a packet outputs only bits 23:16 and 15:8. The second of these, the 188th byte, carries out_eop. The stream's slice position then returns to zero.
- R8: The four streams keep separate slice positions and sequence state. Interleaved words reassemble each stream correctly, and each byte is tagged with its stream index on out_stream.
- R9: While out_valid is high and out_ready low, out_byte, out_stream, out_sop and out_eop hold steady and the input is stalled. No byte is lost or repeated.
- R10: During and right after reset, out_valid is low, in_ready is high and no event is pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block can take a word this cycle |
| in_word | input | 32 | Micro-packet word |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Downstream takes the byte |
| out_byte | output | 8 | Reassembled packet byte |
| out_stream | output | 2 | Stream index of out_byte |
| out_sop | output | 1 | First byte of a packet |
| out_eop | output | 1 | 188th byte of a packet |
| loss_evt | output | 4 | Per-stream sequence-gap pulse |
| ovf_evt | output | 4 | Per-stream upstream-overflow pulse |

## Verification
The assertions make three assumptions about the inputs. The output consumer may stall at any time. The producer holds in_valid and in_word until a word is taken. A packet starts with a flagged word before any of its continuation slices arrive. The stimulus follows these rules: the producer task keeps each word on the port until in_ready is seen at an accepting edge, and every packet is opened with a start-flagged slice. On top of that the stimulus sends words with reserved tags, stray continuations, a mid-packet restart, sequence gaps and overflow flags, with the consumer's ready driven pseudo-randomly during the interleaved phase.

// File: rtl/mpr_pkg.sv
package mpr_pkg;
   localparam int WORD_W  = 32;
   localparam int PAY_W   = 24;
   localparam int SEQ_W   = 3;
   localparam int TAG_W   = 3;
   localparam int BYTE_W  = 8;

   // field layout follows the wire format of a micro-packet word
   typedef struct packed {
      logic [TAG_W-1:0] tag;
      logic [SEQ_W-1:0] seq;
      logic             start;
      logic             ovf;
      logic [PAY_W-1:0] pay;
   } mp_word_t;
endpackage

// File: rtl/mpr_word_decode.sv
module mpr_word_decode #(
   parameter int NUM_STREAMS = 4,
   parameter int SID_W       = 2
) (
   input  logic [31:0]      word_i,
   output logic             tag_ok_o,
   output logic [SID_W-1:0] sid_o,
   output logic             start_o,
   output logic             ovf_o,
   output logic [2:0]       seq_o,
   output logic [23:0]      pay_o
);
   import mpr_pkg::*;

   mp_word_t          w;
   logic [TAG_W-1:0]  tag_m1;

   always_comb begin
      w        = mp_word_t'(word_i);
      tag_m1   = w.tag - 3'd1;
      tag_ok_o = (w.tag != '0) && (w.tag <= 3'(NUM_STREAMS));
      sid_o    = tag_m1[SID_W-1:0];
      start_o  = w.start;
      ovf_o    = w.ovf;
      seq_o    = w.seq;
      pay_o    = w.pay;
   end
endmodule

// File: rtl/mpr_lane.sv
module mpr_lane #(
   parameter int SLICES_PER_PKT = 63,
   parameter int SLICE_W        = 6,
   parameter int SEQ_W          = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               hit_i,
   input  logic               start_i,
   input  logic [SEQ_W-1:0]   seq_i,
   output logic               keep_o,
   output logic               loss_o,
   output logic [SLICE_W-1:0] slice_o
);
   localparam logic [SLICE_W-1:0] LAST = SLICE_W'(SLICES_PER_PKT - 1);

   logic [SLICE_W-1:0] slice_q;
   logic [SEQ_W-1:0]   seq_q;
   logic               seen_q;
   logic [SEQ_W-1:0]   seq_exp;

   always_comb begin
      slice_o = start_i ? '0 : slice_q;
      keep_o  = start_i || (slice_q != '0);
      seq_exp = seq_q + 1'b1;
      loss_o  = seen_q && (seq_i != seq_exp);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slice_q <= '0;
         seq_q   <= '0;
         seen_q  <= 1'b0;
      end else if (hit_i) begin
         seq_q  <= seq_i;
         seen_q <= 1'b1;
         if (keep_o)
            slice_q <= (slice_o == LAST) ? '0 : slice_o + 1'b1;
      end
   end
endmodule

// File: rtl/mpr_serializer.sv
module mpr_serializer #(
   parameter int SLICE_BYTES = 3,
   parameter int SID_W       = 2,
   parameter int CNT_W       = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     load_i,
   input  logic [SLICE_BYTES*8-1:0] data_i,
   input  logic [CNT_W-1:0]         nbytes_i,
   input  logic                     sop_i,
   input  logic                     eop_i,
   input  logic [SID_W-1:0]         sid_i,
   output logic                     ready_o,
   output logic                     valid_o,
   input  logic                     take_i,
   output logic [7:0]               byte_o,
   output logic [SID_W-1:0]         sid_o,
   output logic                     sop_o,
   output logic                     eop_o
);
   localparam int DATA_W = SLICE_BYTES * 8;

   logic [DATA_W-1:0] data_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              sop_q;
   logic              eop_q;
   logic [SID_W-1:0]  sid_q;

   always_comb begin
      valid_o = (cnt_q != '0);
      ready_o = (cnt_q == '0) || ((cnt_q == CNT_W'(1)) && take_i);
      byte_o  = data_q[DATA_W-1 -: 8];
      sid_o   = sid_q;
      sop_o   = sop_q;
      eop_o   = eop_q && (cnt_q == CNT_W'(1));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data_q <= '0;
         cnt_q  <= '0;
         sop_q  <= 1'b0;
         eop_q  <= 1'b0;
         sid_q  <= '0;
      end else if (load_i) begin
         data_q <= data_i;
         cnt_q  <= nbytes_i;
         sop_q  <= sop_i;
         eop_q  <= eop_i;
         sid_q  <= sid_i;
      end else if (valid_o && take_i) begin
         data_q <= data_q << 8;
         cnt_q  <= cnt_q - 1'b1;
         sop_q  <= 1'b0;
      end
   end
endmodule

// File: rtl/mpr_ts_reassembler.sv
module mpr_ts_reassembler #(
   parameter int NUM_STREAMS    = 4,
   parameter int SLICES_PER_PKT = 63,
   parameter int SLICE_BYTES    = 3,
   parameter int TAIL_BYTES     = 2,
   parameter int SID_W          = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   output logic                   in_ready,
   input  logic [31:0]            in_word,
   output logic                   out_valid,
   input  logic                   out_ready,
   output logic [7:0]             out_byte,
   output logic [SID_W-1:0]       out_stream,
   output logic                   out_sop,
   output logic                   out_eop,
   output logic [NUM_STREAMS-1:0] loss_evt,
   output logic [NUM_STREAMS-1:0] ovf_evt
);
   import mpr_pkg::*;

   localparam int SLICE_W = $clog2(SLICES_PER_PKT);
   localparam int CNT_W   = $clog2(SLICE_BYTES + 1);
   localparam logic [SLICE_W-1:0] LAST = SLICE_W'(SLICES_PER_PKT - 1);

   if (NUM_STREAMS < 1 || NUM_STREAMS > 7) begin : g_bad_streams
      $error("NUM_STREAMS must fit the 3-bit tag (1..7)");
   end
   if (SLICE_BYTES * 8 != PAY_W) begin : g_bad_slice
      $error("SLICE_BYTES must fill the payload field");
   end
   if (TAIL_BYTES < 1 || TAIL_BYTES > SLICE_BYTES) begin : g_bad_tail
      $error("TAIL_BYTES out of range");
   end
   if (SLICES_PER_PKT < 2) begin : g_bad_slices
      $error("SLICES_PER_PKT must be at least 2");
   end

   logic             tag_ok, w_start, w_ovf, accept;
   logic [SID_W-1:0] sid;
   logic [SEQ_W-1:0] w_seq;
   logic [PAY_W-1:0] w_pay;

   logic [NUM_STREAMS-1:0] hit, keep_v, loss_v;
   logic [SLICE_W-1:0]     slice_a [NUM_STREAMS];
   logic                   sel_keep, load;
   logic [SLICE_W-1:0]     sel_slice;
   logic [CNT_W-1:0]       nbytes;

   mpr_word_decode #(.NUM_STREAMS(NUM_STREAMS), .SID_W(SID_W)) u_dec (
      .word_i(in_word), .tag_ok_o(tag_ok), .sid_o(sid), .start_o(w_start),
      .ovf_o(w_ovf), .seq_o(w_seq), .pay_o(w_pay)
   );

   assign accept = in_valid && in_ready;

   for (genvar i = 0; i < NUM_STREAMS; i++) begin : g_lane
      assign hit[i] = accept && tag_ok && (sid == SID_W'(i));

      mpr_lane #(.SLICES_PER_PKT(SLICES_PER_PKT), .SLICE_W(SLICE_W),
                 .SEQ_W(SEQ_W)) u_lane (
         .clk(clk), .rst_n(rst_n), .hit_i(hit[i]), .start_i(w_start),
         .seq_i(w_seq), .keep_o(keep_v[i]), .loss_o(loss_v[i]),
         .slice_o(slice_a[i])
      );

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            loss_evt[i] <= 1'b0;
            ovf_evt[i]  <= 1'b0;
         end else begin
            loss_evt[i] <= hit[i] && loss_v[i];
            ovf_evt[i]  <= hit[i] && w_ovf;
         end
      end
   end

   always_comb begin
      sel_keep  = keep_v[sid];
      sel_slice = slice_a[sid];
      load      = accept && tag_ok && sel_keep;
      nbytes    = (sel_slice == LAST) ? CNT_W'(TAIL_BYTES) : CNT_W'(SLICE_BYTES);
   end

   mpr_serializer #(.SLICE_BYTES(SLICE_BYTES), .SID_W(SID_W), .CNT_W(CNT_W)) u_ser (
      .clk(clk), .rst_n(rst_n), .load_i(load), .data_i(w_pay),
      .nbytes_i(nbytes), .sop_i(sel_slice == '0), .eop_i(sel_slice == LAST),
      .sid_i(sid), .ready_o(in_ready), .valid_o(out_valid),
      .take_i(out_ready), .byte_o(out_byte), .sid_o(out_stream),
      .sop_o(out_sop), .eop_o(out_eop)
   );
endmodule

// File: rtl/mpr_ts_reassembler_chk.sv
module mpr_ts_reassembler_chk #(
   parameter int NUM_STREAMS = 4,
   parameter int SID_W       = 2,
   parameter int PKT_BYTES   = 188
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   in_valid,
   input logic                   in_ready,
   input logic                   out_valid,
   input logic                   out_ready,
   input logic [7:0]             out_byte,
   input logic [SID_W-1:0]       out_stream,
   input logic                   out_sop,
   input logic                   out_eop,
   input logic [NUM_STREAMS-1:0] loss_evt,
   input logic [NUM_STREAMS-1:0] ovf_evt
);
   logic        xfer;
   logic [15:0] run_q [NUM_STREAMS];
   logic [15:0] run_nxt;

   always_comb begin
      xfer    = out_valid && out_ready;
      run_nxt = out_sop ? 16'd1 : run_q[out_stream] + 16'd1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_STREAMS; i++) run_q[i] <= '0;
      end else if (xfer) begin
         run_q[out_stream] <= run_nxt;
      end
   end

   // R9: a stalled byte holds all its attributes
   a_r9_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_byte) &&
      $stable(out_stream) && $stable(out_sop) && $stable(out_eop));

   // R9: input is only held off while output holds a byte
   a_r9_ready_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> in_ready);

   // R7: end marker lands on the 188th byte since the start marker
   a_r7_eop_count: assert property (@(posedge clk) disable iff (!rst_n)
      xfer && out_eop |-> run_nxt == 16'(PKT_BYTES));

   // R8: one word per cycle, so events name at most one stream
   a_r8_one_stream_event: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(loss_evt | ovf_evt));

   // R4: overflow pulse only after an accepted word
   a_r4_ovf_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_evt != '0) |-> $past(in_valid && in_ready));

   // R5: loss pulse only after an accepted word
   a_r5_loss_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (loss_evt != '0) |-> $past(in_valid && in_ready));
endmodule

bind mpr_ts_reassembler mpr_ts_reassembler_chk #(
   .NUM_STREAMS(NUM_STREAMS), .SID_W(SID_W),
   .PKT_BYTES((SLICES_PER_PKT - 1) * SLICE_BYTES + TAIL_BYTES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
   .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte),
   .out_stream(out_stream), .out_sop(out_sop), .out_eop(out_eop),
   .loss_evt(loss_evt), .ovf_evt(ovf_evt)
);

// File: tb/mpr_ts_reassembler_tb.sv
module mpr_ts_reassembler_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [31:0] in_word = '0;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic [7:0]  out_byte;
   logic [1:0]  out_stream;
   logic        out_sop, out_eop;
   logic [3:0]  loss_evt, ovf_evt;

   always #10 clk = ~clk;

   mpr_ts_reassembler dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_word(in_word), .out_valid(out_valid), .out_ready(out_ready),
      .out_byte(out_byte), .out_stream(out_stream), .out_sop(out_sop),
      .out_eop(out_eop), .loss_evt(loss_evt), .ovf_evt(ovf_evt)
   );

   int n_cmp = 0;
   int n_bad = 0;
   bit bp_on = 1'b0;
   bit done  = 1'b0;

   // reference model state
   logic [11:0] expq[$];
   int          m_slice [4];
   int          m_seq   [4];
   bit          m_seen  [4];
   logic [3:0]  exp_loss = '0, exp_ovf = '0;
   logic        hold_v = 1'b0;
   logic [11:0] hold_d;
   int          tx_seq [4];

   task automatic fail(string req, string what, int act, int exp);
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
   endtask

   task automatic cmp(string req, string what, int act, int exp);
      n_cmp++;
      if (act != exp) fail(req, what, act, exp);
   endtask

   function automatic logic [31:0] mk(int tag, bit st, bit ov, int sq, logic [23:0] pay);
      return {3'(tag), 3'(sq), st, ov, pay};
   endfunction

   task automatic model_word(logic [31:0] w);
      int tag, s, n;
      tag = int'(w[31:29]);
      if (tag < 1 || tag > 4) return;
      s = tag - 1;
      exp_ovf[s] = w[24];
      if (m_seen[s] && int'(w[28:26]) != ((m_seq[s] + 1) % 8)) exp_loss[s] = 1'b1;
      m_seq[s]  = int'(w[28:26]);
      m_seen[s] = 1'b1;
      if (w[25]) m_slice[s] = 0;
      else if (m_slice[s] == 0) return;
      n = (m_slice[s] == 62) ? 2 : 3;
      for (int b = 0; b < n; b++) begin
         logic [7:0] by;
         by = w[23 - 8*b -: 8];
         expq.push_back({(b == 0 && m_slice[s] == 0), (b == 1 && m_slice[s] == 62),
                         2'(s), by});
      end
      m_slice[s] = (m_slice[s] == 62) ? 0 : m_slice[s] + 1;
   endtask

   always @(negedge clk) begin
      if (!rst_n) begin
         cmp("R10", "reset out_valid", int'(out_valid), 0);
         cmp("R10", "reset in_ready", int'(in_ready), 1);
      end else if (!done) begin
         cmp("R5", "loss_evt", int'(loss_evt), int'(exp_loss));
         cmp("R4", "ovf_evt", int'(ovf_evt), int'(exp_ovf));
         exp_loss = '0;
         exp_ovf  = '0;
         if (hold_v)
            cmp("R9", "stalled byte changed", int'({out_valid, out_sop, out_eop, out_stream, out_byte}),
                int'({1'b1, hold_d}));
         hold_v = out_valid && !out_ready;
         hold_d = {out_sop, out_eop, out_stream, out_byte};
         if (out_valid) begin
            if (expq.size() == 0) begin
               n_cmp++;
               fail("R1 R3", "unexpected byte", int'(out_byte), 0);
            end else begin
               cmp("R6", "byte", int'(out_byte), int'(expq[0][7:0]));
               cmp("R8", "stream", int'(out_stream), int'(expq[0][9:8]));
               cmp("R2", "sop", int'(out_sop), int'(expq[0][11]));
               cmp("R7", "eop", int'(out_eop), int'(expq[0][10]));
               if (out_ready) void'(expq.pop_front());
            end
         end
         if (in_valid && in_ready) model_word(in_word);
      end
   end

   always @(posedge clk) begin
      #2;
      out_ready <= bp_on ? ($urandom_range(0, 2) != 0) : 1'b1;
   end

   task automatic send(logic [31:0] w);
      in_word  = w;
      in_valid = 1'b1;
      do @(negedge clk); while (!in_ready);
      @(posedge clk);
      #2;
      in_valid = 1'b0;
   endtask

   task automatic slice(int s, int k, bit st, bit ov);
      send(mk(s + 1, st, ov, tx_seq[s], {4'(s), 4'hA, 8'(k), 8'(k * 3 + s)}));
      tx_seq[s] = (tx_seq[s] + 1) % 8;
   endtask

   task automatic drain();
      repeat (12) @(posedge clk);
      #2;
   endtask

   initial begin
      for (int i = 0; i < 4; i++) begin
         m_slice[i] = 0; m_seq[i] = 0; m_seen[i] = 1'b0; tx_seq[i] = 0;
      end
      repeat (5) @(posedge clk);
      #2 rst_n = 1'b1;
      @(posedge clk); #2;

      // R2 R6 R7: one full packet on stream 0
      for (int k = 0; k < 63; k++) slice(0, k, k == 0, 1'b0);
      drain();

      // R1: reserved tags with start flag give nothing
      send(mk(0, 1, 1, 0, 24'h111111));
      send(mk(5, 1, 1, 0, 24'h222222));
      send(mk(6, 1, 0, 0, 24'h333333));
      send(mk(7, 1, 1, 0, 24'h444444));
      // R3: continuation on an idle stream is dropped
      slice(0, 5, 1'b0, 1'b0);
      drain();
      cmp("R1", "queue empty after ignored words", expq.size(), 0);
      cmp("R3", "no output after stray slice", int'(out_valid), 0);

      // R5: discarded first word on stream 2 still records its sequence
      slice(2, 9, 1'b0, 1'b1);
      slice(2, 0, 1'b1, 1'b0);
      drain();

      // R8 R9: interleaved packets with random backpressure
      bp_on = 1'b1;
      slice(1, 0, 1'b1, 1'b0); slice(3, 0, 1'b1, 1'b0); slice(0, 0, 1'b1, 1'b0);
      for (int k = 1; k < 63; k++)
         for (int s = 0; s < 4; s++) slice(s, k, 1'b0, 1'b0);

      // R5: gap on stream 1; R4: overflow flag on stream 3
      tx_seq[1] = (tx_seq[1] + 2) % 8;
      slice(1, 0, 1'b1, 1'b0);
      slice(3, 0, 1'b1, 1'b1);
      // R2: restart stream 1 part-way through, then finish it
      for (int k = 1; k < 10; k++) slice(1, k, 1'b0, 1'b0);
      for (int k = 0; k < 63; k++) slice(1, k, k == 0, 1'b0);
      bp_on = 1'b0;
      drain();
      cmp("R8", "all bytes delivered", expq.size(), 0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(20 * 150000);
      n_bad++;
      $display("FAIL watchdog expired");
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule